// File: doc/BRIEF.md
# Trace Start/Stop Event Combiner

This block watches a vector of debug event lines and decides when a downstream trace capture unit should record. Two independent selection masks pick which events may start tracing and which may stop it. Each direction has its own combine mode. In "any" mode, one selected event is enough. In "all" mode, every selected event must be present in the same cycle. The result is held in a single registered trace-active level that drives the capture unit.

Configuration arrives on a single-cycle write port: an address, a data word one bit per event source, and a write strobe. An event source may belong to the start mask or the stop mask, but never to both. Any write that would put a source into both masks has those bits removed from the incoming value, and a sticky error flag records that this happened. The remaining bits of that write are still stored.

Top module: `trace_gate`

## Requirements
- R1: After synchronous reset, `trace_active` and `cfg_err` are 0, both masks are all zeros and both combine modes are "any". Reset also clears a previously set `cfg_err`.
- R2: A write with `wr_en`=1 stores `wr_data` at the next rising edge, and the stored value governs the request logic from the following cycle. The register map is: address 0 holds the start mask and address 1 holds the stop mask. Address 2 holds the control word, where bit 0 is the start mode and bit 1 is the stop mode, with 1 meaning "all" and 0 meaning "any". Writes to address 3 change nothing.
- R3: In "any" mode, a request fires in any cycle in which at least one event selected by the mask is high.
- R4: In "all" mode, a request fires only in a cycle in which every event selected by the mask is high. Unselected events being high as well does not prevent it.
- R5: A mask of all zeros never issues a request, in either mode, whatever the events.
- R6: When a write to one mask carries bits that are already set in the other mask, those bits are cleared in the stored value and the other bits of the write are kept. As a result, the two masks never share a set bit.
- R7: Such a conflicting write sets `cfg_err`, which stays 1 until reset.
- R8: `trace_active` becomes 1 at the edge that ends a cycle with a start request and no stop request. It becomes 0 at the edge that ends a cycle with a stop request. Otherwise it holds its value.
- R9: When start and stop requests fire in the same cycle, the stop request wins and `trace_active` becomes 0.
- R10: Events whose mask bit is 0 have no effect on `trace_active`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W (2) | Register address |
| wr_data | input | NUM_SRC (16) | Write data, one bit per event source |
| events | input | NUM_SRC (16) | Debug event inputs, sampled every cycle |
| trace_active | output | 1 | Registered level telling the capture unit to record |
| cfg_err | output | 1 | Sticky flag set by a write that would overlap the masks |

## Verification
The bench drives single events, partial and complete sets of the selected events, and full-width event words. Each pattern is applied in both combine modes, so the tests separate "any" behaviour from "all" behaviour, and separate selected inputs from unselected ones. Some patterns set start and stop events together, which shows whether stop takes priority. Other patterns are applied with one mask left empty, which shows that an empty mask never fires. A directed sequence writes one mask over the other and then probes both the removed and the kept bits through `trace_active`. It also checks that `cfg_err` stays set until reset.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;

  typedef enum logic {
    MODE_ANY = 1'b0,
    MODE_ALL = 1'b1
  } combine_e;

  localparam int unsigned ADDR_START = 0;
  localparam int unsigned ADDR_STOP  = 1;
  localparam int unsigned ADDR_CTRL  = 2;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;

endpackage

// File: rtl/trace_gate_regs.sv
module trace_gate_regs
  import trace_gate_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] start_mask,
  output logic [NUM_SRC-1:0] stop_mask,
  output combine_e           start_mode,
  output combine_e           stop_mode,
  output logic               cfg_err
);

  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(ADDR_START);
  localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(ADDR_STOP);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);

  logic               hit_start;
  logic               hit_stop;
  logic               hit_ctrl;
  logic [NUM_SRC-1:0] clash;

  assign hit_start = wr_en && (wr_addr == A_START);
  assign hit_stop  = wr_en && (wr_addr == A_STOP);
  assign hit_ctrl  = wr_en && (wr_addr == A_CTRL);

  always_comb begin
    clash = '0;
    if (hit_start) clash = wr_data & stop_mask;
    if (hit_stop)  clash = wr_data & start_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_mask <= '0;
      stop_mask  <= '0;
      start_mode <= MODE_ANY;
      stop_mode  <= MODE_ANY;
      cfg_err    <= 1'b0;
    end else begin
      if (hit_start) start_mask <= wr_data & ~clash;
      if (hit_stop)  stop_mask  <= wr_data & ~clash;
      if (hit_ctrl) begin
        start_mode <= combine_e'(wr_data[CTRL_START_BIT]);
        stop_mode  <= combine_e'(wr_data[CTRL_STOP_BIT]);
      end
      if (clash != '0) cfg_err <= 1'b1;
    end
  end

  a_r6_masks_disjoint: assert property (@(posedge clk) disable iff (rst)
    (start_mask & stop_mask) == '0);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  a_r7_err_on_start_clash: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_START && (wr_data & stop_mask) != '0) |=> cfg_err);

  a_r7_err_on_stop_clash: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STOP && (wr_data & start_mask) != '0) |=> cfg_err);

  a_r2_unused_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit_start && !hit_stop && !hit_ctrl)
      |=> ($stable(start_mask) && $stable(stop_mask) && $stable(start_mode)
           && $stable(stop_mode)));

endmodule

// File: rtl/trace_gate_combine.sv
module trace_gate_combine
  import trace_gate_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic [NUM_SRC-1:0] events,
  input  logic [NUM_SRC-1:0] mask,
  input  combine_e           mode,
  output logic               req
);

  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] miss;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hit[i]  = mask[i] & events[i];
    assign miss[i] = mask[i] & ~events[i];
  end

  logic armed;
  logic any_hit;
  logic none_missing;

  assign armed        = |mask;
  assign any_hit      = |hit;
  assign none_missing = ~|miss;

  always_comb begin
    unique case (mode)
      MODE_ALL: req = armed & none_missing;
      default:  req = armed & any_hit;
    endcase
  end

  always_comb begin
    if (mask == '0) begin
      a_r5_empty_mask_silent: assert (!req);
    end
    if (req && mode == MODE_ALL) begin
      a_r4_all_present: assert ((events & mask) == mask);
    end
    if (req && mode == MODE_ANY) begin
      a_r3_some_present: assert ((events & mask) != '0);
    end
  end

endmodule

// File: rtl/trace_gate.sv
module trace_gate
  import trace_gate_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [NUM_SRC-1:0] events,
  output logic               trace_active,
  output logic               cfg_err
);

  logic [NUM_SRC-1:0] start_mask;
  logic [NUM_SRC-1:0] stop_mask;
  combine_e           start_mode;
  combine_e           stop_mode;
  logic               start_req;
  logic               stop_req;

  trace_gate_regs #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .start_mask (start_mask),
    .stop_mask  (stop_mask),
    .start_mode (start_mode),
    .stop_mode  (stop_mode),
    .cfg_err    (cfg_err)
  );

  trace_gate_combine #(.NUM_SRC(NUM_SRC)) u_start (
    .events (events),
    .mask   (start_mask),
    .mode   (start_mode),
    .req    (start_req)
  );

  trace_gate_combine #(.NUM_SRC(NUM_SRC)) u_stop (
    .events (events),
    .mask   (stop_mask),
    .mode   (stop_mode),
    .req    (stop_req)
  );

  always_ff @(posedge clk) begin
    if (rst)            trace_active <= 1'b0;
    else if (stop_req)  trace_active <= 1'b0;
    else if (start_req) trace_active <= 1'b1;
  end

  a_r9_stop_wins: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !trace_active);

  a_r8_start_sets: assert property (@(posedge clk) disable iff (rst)
    (start_req && !stop_req) |=> trace_active);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_req && !stop_req) |=> $stable(trace_active));

endmodule

// File: tb/trace_gate_tb.sv
module trace_gate_tb;

  localparam int unsigned NUM_SRC = 16;
  localparam int unsigned ADDR_W  = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  wr_addr = '0;
  logic [NUM_SRC-1:0] wr_data = '0;
  logic [NUM_SRC-1:0] events = '0;
  logic               trace_active;
  logic               cfg_err;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  trace_gate #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .events       (events),
    .trace_active (trace_active),
    .cfg_err      (cfg_err)
  );

  // Fields: start mask, stop mask, ctrl[1:0], prime, events, expected active
  localparam int NV = 14;
  localparam logic [51:0] TBL [NV] = '{
    {16'h0003, 16'h0000, 2'b00, 1'b0, 16'h0001, 1'b1}, // R3 one selected fires
    {16'h0003, 16'h0000, 2'b00, 1'b0, 16'h0004, 1'b0}, // R10 unselected ignored
    {16'h0003, 16'h0000, 2'b01, 1'b0, 16'h0001, 1'b0}, // R4 partial set
    {16'h0003, 16'h0000, 2'b01, 1'b0, 16'h0003, 1'b1}, // R4 full set
    {16'h0003, 16'h0000, 2'b01, 1'b0, 16'hFFFF, 1'b1}, // R4 extra bits allowed
    {16'h0000, 16'h00F0, 2'b00, 1'b0, 16'hFFFF, 1'b0}, // R5 empty start mask
    {16'h000F, 16'h00F0, 2'b00, 1'b1, 16'h0010, 1'b0}, // R8 stop in any mode
    {16'h000F, 16'h00F0, 2'b10, 1'b1, 16'h0030, 1'b1}, // R4 partial stop holds
    {16'h000F, 16'h00F0, 2'b10, 1'b1, 16'h00F0, 1'b0}, // R4 full stop clears
    {16'h000F, 16'h0000, 2'b00, 1'b1, 16'hFFF0, 1'b1}, // R5 empty stop mask
    {16'h000F, 16'h00F0, 2'b00, 1'b1, 16'h0011, 1'b0}, // R9 both fire
    {16'h8000, 16'h0001, 2'b11, 1'b0, 16'h8001, 1'b0}, // R9 both fire, all mode
    {16'h000F, 16'h00F0, 2'b00, 1'b0, 16'h0000, 1'b0}, // R8 hold inactive
    {16'hFFFF, 16'h0000, 2'b01, 1'b0, 16'hFFFF, 1'b1}  // R4 full width
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic write_reg(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] ev);
    @(negedge clk); events = ev;
    @(negedge clk); events = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 active after reset", 32'(trace_active), 32'd0);
    check("R1 err after reset", 32'(cfg_err), 32'd0);
    pulse('1);
    check("R1 masks empty after reset", 32'(trace_active), 32'd0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_reg(2'd0, TBL[v][51:36]);
      write_reg(2'd1, TBL[v][35:20]);
      write_reg(2'd2, {14'd0, TBL[v][19:18]});
      if (TBL[v][17]) pulse(TBL[v][51:36]);
      pulse(TBL[v][16:1]);
      check($sformatf("R2/R3/R4/R5/R8/R9/R10 vector %0d", v),
            32'(trace_active), 32'(TBL[v][0]));
      check($sformatf("R7 no error vector %0d", v), 32'(cfg_err), 32'd0);
    end

    // R1: reset clears a configured mask
    write_reg(2'd0, 16'h0001);
    do_reset();
    pulse('1);
    check("R1 mask cleared by reset", 32'(trace_active), 32'd0);

    // R2: address 3 changes nothing
    write_reg(2'd0, 16'h0001);
    write_reg(2'd3, 16'hFFFF);
    pulse(16'h0002);
    check("R2 unused address ignored", 32'(trace_active), 32'd0);
    pulse(16'h0001);
    check("R2 start mask intact", 32'(trace_active), 32'd1);

    // R6/R7: overlapping writes
    do_reset();
    write_reg(2'd1, 16'h00FF);
    check("R7 no error yet", 32'(cfg_err), 32'd0);
    write_reg(2'd0, 16'h0F0F);
    check("R7 error set", 32'(cfg_err), 32'd1);
    pulse(16'h000F);
    check("R6 overlapping bits dropped", 32'(trace_active), 32'd0);
    pulse(16'h0100);
    check("R6 other bits kept", 32'(trace_active), 32'd1);
    write_reg(2'd1, 16'h0100);
    pulse(16'h00FF);
    check("R6 stop write scrubbed to empty", 32'(trace_active), 32'd1);
    repeat (3) @(negedge clk);
    check("R7 error sticky", 32'(cfg_err), 32'd1);
    do_reset();
    check("R1 error cleared by reset", 32'(cfg_err), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule